// File: doc/BRIEF.md
# SPI Mode-3 Byte-Addressed Register Slave

This block is a serial slave that lets an external host reach a small bank of 16-bit registers over a four-wire SPI link running in mode 3 (clock idles high, data launched on the falling edge and captured on the rising edge, most significant bit first). Every transfer is a 16-bit frame. The top bit selects write (1) or read (0), the next seven bits give a byte address, and the low eight bits carry write data. Each 16-bit register answers to two byte addresses: the even one is its low byte, the odd one its high byte. A write changes exactly one byte. A read command is answered in the frame that follows it, so the host can issue the next command while it collects the previous answer.

The serial pins are brought into a fast system clock through two-stage synchronisers, and the serial clock edges are found by comparing synchronised samples. The system clock must be at least eight times the serial clock. Word indices below `NUM_OUT` are output registers. Their low 15 bits are loaded by the surrounding logic through per-register load strobes, and bit 15 flags fresh data. The next word holds status. The word after that takes commands, and each command bit is pulsed for a single system clock. All remaining words are plain read/write configuration registers, exported flat. When chip select rises after a number of serial clocks that is not a multiple of 16, a sticky framing-error flag is set and the unfinished frame is thrown away.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset `miso` is 0, every configuration word reads 0 on `cfg_flat`, and `cmd_pulse` stays 0.
- R2: Frame layout is bit 15 = write (1) / read (0), bits 14:8 = byte address, bits 7:0 = write data. DIN is captured on rising SCLK, DOUT is launched on falling SCLK, MSB first.
- R3: A write to configuration word w at byte address 2w changes only bits 7:0, and at 2w+1 only bits 15:8. It takes effect only when the 16th rising edge of a frame completes, and nothing else changes `cfg_flat`.
- R4: A read command returns, during the next frame, the full 16-bit value the register held when the command frame completed. Both byte addresses of a word return the same word, and back-to-back read commands pipeline with one frame of delay.
- R5: Output word i (i < NUM_OUT, byte addresses 2i and 2i+1) reads {nd, data[14:0]}. A load strobe sets nd to 1 and stores the data, a read of that word clears nd, and host writes to it have no effect.
- R6: Status word NUM_OUT (byte addresses 2·NUM_OUT and 2·NUM_OUT+1) has the framing-error flag in bit 0, other bits 0. The flag is set when chip select rises with a bit count not a multiple of 16, it stays set until the status word is read, and that read clears it. A frame cut short commits no write.
- R7: Writing a byte to command word NUM_OUT+1 drives `cmd_pulse` high for exactly one system clock after the frame's 16th rising edge, with the data in bits 7:0 (even address) or 15:8 (odd address). Reading the command word returns 0, and a cut-short frame produces no pulse.
- R8: DOUT is 0 throughout a frame not preceded by a read command, and 0 while chip select is high. Byte addresses beyond word NUM_REGS-1 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| smp_load | input | NUM_OUT | Per-output-register load strobe |
| smp_data | input | NUM_OUT*15 | Output register data, 15 bits per register, register 0 in the low bits |
| cfg_flat | output | (NUM_REGS-NUM_OUT-2)*16 | Configuration words, first one in the low bits |
| cmd_pulse | output | 16 | One-clock command strobes |

## Verification
The hardest condition to reach from the ports is a frame cut short at an arbitrary bit count. The bench reaches it with a transfer task that takes the number of serial clocks as an argument and raises chip select after 10 or 12 pulses. The read-back that proves no write or command escaped is only visible one frame later, because of the pipelined reads. Each read is therefore followed by a dummy read of an unmapped address, and a second status read confirms that the first one cleared the flag.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int OUT_DATA_W = 15;
    localparam int ERR_BIT    = 0;

    typedef struct packed {
        logic       wr;
        logic [6:0] addr;
        logic [7:0] data;
    } frame_t;

    function automatic logic [5:0] word_of(input logic [6:0] byte_addr);
        return byte_addr[6:1];
    endfunction

    function automatic logic [15:0] merge_byte(input logic [15:0] old_val,
                                               input logic        hi,
                                               input logic [7:0]  d);
        return hi ? {d, old_val[7:0]} : {old_val[15:8], d};
    endfunction

endpackage

// File: rtl/spi_frame_io.sv
module spi_frame_io
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    input  logic [15:0] tx_word,
    input  logic        tx_valid,
    output logic        miso,
    output logic        frame_done,
    output frame_t      rx_word,
    output logic        partial_err
);
    localparam int CW = $clog2(FRAME_BITS);

    logic [SYNC_STAGES:0]   cs_sh, sck_sh;
    logic [SYNC_STAGES-1:0] din_sh;
    logic [CW-1:0]          cnt;
    logic [FRAME_BITS-2:0]  shreg;

    logic cs_s, cs_d, sck_s, sck_d, din_s;
    logic sck_rise, sck_fall, cs_rise;
    logic [CW-1:0] bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sh  <= '1;
            sck_sh <= '1;
            din_sh <= '0;
        end else begin
            cs_sh  <= {cs_sh[SYNC_STAGES-1:0], cs_n};
            sck_sh <= {sck_sh[SYNC_STAGES-1:0], sclk};
            din_sh <= {din_sh[SYNC_STAGES-2:0], mosi};
        end
    end

    always_comb begin
        cs_s     = cs_sh[SYNC_STAGES-1];
        cs_d     = cs_sh[SYNC_STAGES];
        sck_s    = sck_sh[SYNC_STAGES-1];
        sck_d    = sck_sh[SYNC_STAGES];
        din_s    = din_sh[SYNC_STAGES-1];
        sck_rise = sck_s & ~sck_d & ~cs_s;
        sck_fall = ~sck_s & sck_d & ~cs_s;
        cs_rise  = cs_s & ~cs_d;
        bit_idx  = ~cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            shreg       <= '0;
            miso        <= 1'b0;
            frame_done  <= 1'b0;
            rx_word     <= '0;
            partial_err <= 1'b0;
        end else begin
            frame_done  <= 1'b0;
            partial_err <= 1'b0;
            if (cs_rise) begin
                partial_err <= (cnt != '0);
                cnt         <= '0;
                miso        <= 1'b0;
            end else if (sck_rise) begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[FRAME_BITS-3:0], din_s};
                if (cnt == CW'(FRAME_BITS - 1)) begin
                    frame_done <= 1'b1;
                    rx_word    <= {shreg, din_s};
                end
            end else if (sck_fall) begin
                miso <= tx_valid ? tx_word[bit_idx] : 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int NUM_OUT  = 3,
    localparam int NUM_CFG = NUM_REGS - NUM_OUT - 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_done,
    input  frame_t                     rx_word,
    input  logic                       partial_err,
    input  logic [NUM_OUT-1:0]         smp_load,
    input  logic [NUM_OUT*OUT_DATA_W-1:0] smp_data,
    output logic [15:0]                tx_word,
    output logic                       tx_valid,
    output logic [NUM_CFG*16-1:0]      cfg_flat,
    output logic [15:0]                cmd_pulse,
    output logic [NUM_OUT-1:0]         nd_q,
    output logic                       err_q
);
    localparam logic [5:0] STAT_IDX = 6'(NUM_OUT);
    localparam logic [5:0] CMD_IDX  = 6'(NUM_OUT + 1);
    localparam int         CFG_BASE = NUM_OUT + 2;

    logic [OUT_DATA_W-1:0] out_data [NUM_OUT];
    logic [15:0]           cfg_q    [NUM_CFG];
    logic [5:0]            w;
    logic                  hi, commit_wr, commit_rd;
    logic [15:0]           rd_val;

    always_comb begin
        w         = word_of(rx_word.addr);
        hi        = rx_word.addr[0];
        commit_wr = frame_done & rx_word.wr;
        commit_rd = frame_done & ~rx_word.wr;
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                nd_q[i]     <= 1'b0;
                out_data[i] <= '0;
            end else if (smp_load[i]) begin
                nd_q[i]     <= 1'b1;
                out_data[i] <= smp_data[i*OUT_DATA_W +: OUT_DATA_W];
            end else if (commit_rd && w == 6'(i)) begin
                nd_q[i] <= 1'b0;
            end
        end
    end

    for (genvar j = 0; j < NUM_CFG; j++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[j] <= '0;
            else if (commit_wr && w == 6'(CFG_BASE + j))
                cfg_q[j] <= merge_byte(cfg_q[j], hi, rx_word.data);
        end
        assign cfg_flat[j*16 +: 16] = cfg_q[j];
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_OUT; i++)
            if (w == 6'(i)) rd_val = {nd_q[i], out_data[i]};
        if (w == STAT_IDX) rd_val[ERR_BIT] = err_q;
        for (int j = 0; j < NUM_CFG; j++)
            if (w == 6'(CFG_BASE + j)) rd_val = cfg_q[j];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q     <= 1'b0;
            cmd_pulse <= '0;
            tx_word   <= '0;
            tx_valid  <= 1'b0;
        end else begin
            if (partial_err)
                err_q <= 1'b1;
            else if (commit_rd && w == STAT_IDX)
                err_q <= 1'b0;

            if (commit_wr && w == CMD_IDX)
                cmd_pulse <= hi ? {rx_word.data, 8'h00} : {8'h00, rx_word.data};
            else
                cmd_pulse <= '0;

            if (commit_rd) begin
                tx_word  <= rd_val;
                tx_valid <= 1'b1;
            end else if (commit_wr) begin
                tx_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int NUM_OUT     = 3,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_CFG    = NUM_REGS - NUM_OUT - 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sclk,
    input  logic                          cs_n,
    input  logic                          mosi,
    output logic                          miso,
    input  logic [NUM_OUT-1:0]            smp_load,
    input  logic [NUM_OUT*OUT_DATA_W-1:0] smp_data,
    output logic [NUM_CFG*16-1:0]         cfg_flat,
    output logic [15:0]                   cmd_pulse
);
    logic        frame_done, partial_err, tx_valid, err_q;
    logic [15:0] tx_word;
    logic [NUM_OUT-1:0] nd_q;
    frame_t      rx_frame;

    spi_frame_io #(.SYNC_STAGES(SYNC_STAGES)) i_io (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .tx_word    (tx_word),
        .tx_valid   (tx_valid),
        .miso       (miso),
        .frame_done (frame_done),
        .rx_word    (rx_frame),
        .partial_err(partial_err)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS), .NUM_OUT(NUM_OUT)) i_bank (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .rx_word    (rx_frame),
        .partial_err(partial_err),
        .smp_load   (smp_load),
        .smp_data   (smp_data),
        .tx_word    (tx_word),
        .tx_valid   (tx_valid),
        .cfg_flat   (cfg_flat),
        .cmd_pulse  (cmd_pulse),
        .nd_q       (nd_q),
        .err_q      (err_q)
    );

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
    parameter int CFG_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             miso,
    input logic             load0,
    input logic             nd0,
    input logic             partial_err,
    input logic             err_q,
    input logic             frame_done,
    input logic [15:0]      cmd_pulse,
    input logic [CFG_W-1:0] cfg_flat
);
    AST_CFG_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(cfg_flat)); // R3

    AST_ND_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        load0 |=> nd0); // R5

    AST_ERR_ON_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        partial_err |=> err_q); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !frame_done) |=> err_q); // R6

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_pulse != 16'h0000) |=> (cmd_pulse == 16'h0000)); // R7

    AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso); // R8

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.CFG_W(NUM_CFG*16)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .miso       (miso),
    .load0      (smp_load[0]),
    .nd0        (nd_q[0]),
    .partial_err(partial_err),
    .err_q      (err_q),
    .frame_done (frame_done),
    .cmd_pulse  (cmd_pulse),
    .cfg_flat   (cfg_flat)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
    localparam int NUM_REGS = 8;
    localparam int NUM_OUT  = 3;
    localparam int NUM_CFG  = NUM_REGS - NUM_OUT - 2;
    localparam int HALF     = 8;
    localparam logic [6:0] DUMMY = 7'h7E;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [NUM_OUT-1:0]    smp_load = '0;
    logic [NUM_OUT*15-1:0] smp_data = '0;
    logic [NUM_CFG*16-1:0] cfg_flat;
    logic [15:0]           cmd_pulse;

    int errors = 0, checks = 0, pulse_cnt = 0;
    logic [15:0] pulse_last = '0;
    logic [15:0] exp_cfg [NUM_CFG];
    bit done = 0;

    always #10 clk = ~clk;

    spi_reg_slave #(.NUM_REGS(NUM_REGS), .NUM_OUT(NUM_OUT)) i_spi_reg_slave (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .smp_load(smp_load), .smp_data(smp_data), .cfg_flat(cfg_flat), .cmd_pulse(cmd_pulse)
    );

    always @(negedge clk) if (!rst && cmd_pulse != 16'h0000) begin
        pulse_cnt  <= pulse_cnt + 1;
        pulse_last <= cmd_pulse;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = tx[15-i];
            repeat (HALF) @(negedge clk);
            rx = {rx[14:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [15:0] junk;
        xfer({1'b1, a, d}, 16, junk);
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] v);
        logic [15:0] junk;
        xfer({1'b0, a, 8'h00}, 16, junk);
        xfer({1'b0, DUMMY, 8'h00}, 16, v);
    endtask

    task automatic load(input int idx, input logic [14:0] d);
        @(negedge clk);
        smp_load[idx] = 1'b1;
        smp_data[idx*15 +: 15] = d;
        @(negedge clk);
        smp_load = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        int base;
        for (int j = 0; j < NUM_CFG; j++) exp_cfg[j] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 miso", {31'd0, miso}, 32'd0);
        chk("R1 cfg", cfg_flat, '0);
        chk("R1 pulses", pulse_cnt, 0);

        // R2 R3 R4 sweep of every configuration byte address with several patterns
        base = 2 * (NUM_OUT + 2);
        for (int a = base; a < 2 * NUM_REGS; a++) begin
            for (int p = 0; p < 3; p++) begin
                logic [7:0] d;
                int wi;
                d  = 8'((a * 37 + p * 91 + 5) ^ (p == 2 ? 8'hFF : 8'h00));
                wi = a / 2 - (NUM_OUT + 2);
                wr(7'(a), d);
                if (a % 2 == 1) exp_cfg[wi][15:8] = d; else exp_cfg[wi][7:0] = d;
                rd(7'(a & ~1), v);
                chk("R3 byte write even read", v, exp_cfg[wi]);
                rd(7'(a | 1), v);
                chk("R4 odd address read", v, exp_cfg[wi]);
                chk("R2 cfg port", cfg_flat[wi*16 +: 16], exp_cfg[wi]);
            end
        end

        // R4 back-to-back pipelined reads
        xfer({1'b0, 7'(base), 8'h00}, 16, v);
        xfer({1'b0, 7'(base + 2), 8'h00}, 16, v);
        chk("R4 pipeline first", v, exp_cfg[0]);
        xfer({1'b0, DUMMY, 8'h00}, 16, v);
        chk("R4 pipeline second", v, exp_cfg[1]);

        // R5 output registers
        load(1, 15'h1234);
        rd(7'd2, v);
        chk("R5 nd set", v, 16'h9234);
        rd(7'd3, v);
        chk("R5 nd cleared", v, 16'h1234);
        wr(7'd2, 8'hFF);
        rd(7'd2, v);
        chk("R5 write ignored", v, 16'h1234);
        @(negedge clk);
        smp_load = 3'b101;
        smp_data = {15'h7FFF, 15'h0000, 15'h0001};
        @(negedge clk);
        smp_load = '0;
        rd(7'd5, v);
        chk("R5 reg2", v, 16'hFFFF);
        rd(7'd0, v);
        chk("R5 reg0", v, 16'h8001);

        // R6 partial frame
        xfer({1'b1, 7'(base), 8'hAA}, 10, v);
        rd(7'(2 * NUM_OUT), v);
        chk("R6 error set", v, 16'h0001);
        rd(7'(2 * NUM_OUT + 1), v2);
        chk("R6 error cleared by read", v2, 16'h0000);
        chk("R6 no partial commit", cfg_flat[15:0], exp_cfg[0]);

        // R7 command pulses
        v = 16'(pulse_cnt);
        wr(7'(2 * NUM_OUT + 2), 8'h3C);
        chk("R7 pulse count lo", pulse_cnt, int'(v) + 1);
        chk("R7 pulse value lo", pulse_last, 16'h003C);
        wr(7'(2 * NUM_OUT + 3), 8'h81);
        chk("R7 pulse count hi", pulse_cnt, int'(v) + 2);
        chk("R7 pulse value hi", pulse_last, 16'h8100);
        xfer({1'b1, 7'(2 * NUM_OUT + 2), 8'hFF}, 12, v2);
        chk("R7 partial no pulse", pulse_cnt, int'(v) + 2);
        rd(7'(2 * NUM_OUT + 2), v2);
        chk("R7 reads zero", v2, 16'h0000);
        rd(7'(2 * NUM_OUT), v2);
        chk("R6 second partial flagged", v2, 16'h0001);

        // R8 idle output and unmapped addresses
        wr(7'(base), 8'h11);
        exp_cfg[0][7:0] = 8'h11;
        xfer({1'b0, DUMMY, 8'h00}, 16, v);
        chk("R8 dout after write", v, 16'h0000);
        wr(7'h20, 8'h55);
        rd(7'h20, v);
        chk("R8 unmapped read", v, 16'h0000);
        for (int j = 0; j < NUM_CFG; j++)
            chk("R8 unmapped write no effect", cfg_flat[j*16 +: 16], exp_cfg[j]);
        chk("R8 miso idle", {31'd0, miso}, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule